// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Third-Order Noise Shaping

This block sits in the feedback path of a fractional-N PLL. It divides the oscillator clock by a ratio that changes from one output period to the next. The ratio is an integer setting plus a small signed correction. A third-order cascaded-accumulator modulator produces that correction, so its error is pushed toward high offset frequencies, where the loop filter removes it. Over a long run, the mean ratio equals the integer setting plus the programmed fraction plus half of the fraction's least significant step. Because of that half step, the modulator never settles into a static state, even when the programmed fraction is zero.

The block marks the last input clock of each period with a one-cycle pulse. The phase detector uses this pulse as the divided feedback edge. A down-counter reloads in the same cycle as the pulse, so no clock is lost between periods. The integer setting, the fraction and the integer-only mode are sampled only in the pulse cycle. Software can therefore change them at any time without corrupting the period that is running. In integer-only mode the modulator is frozen and the ratio equals the integer setting on every period.

Top module: `frac_fb_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 1 and `cur_ratio` is 1. Reset clears every modulator accumulator and delay stage, so the same inputs give the same sequence of period lengths after each reset.
- R2: `div_pulse` is high for exactly one input clock: the last clock of each output period. Consecutive pulses are exactly `cur_ratio` clocks apart, with no dead cycle. With a ratio of 1, the pulse stays high on every clock.
- R3: `int_val`, `frac_val` and `int_only` are sampled only in a cycle where `div_pulse` is high. `cur_ratio` takes the new ratio on the clock edge that ends the pulse cycle and holds it at every other edge. A change in the middle of a period does not alter that period.
- R4: When `int_only` is 1, every period is exactly `int_val` clocks and `frac_val` has no effect.
- R5: When `int_only` is 0 and `int_val` is at least 4, every period lies between `int_val`-3 and `int_val`+4 clocks.
- R6: When `int_only` is 0 and the inputs are held constant, any 2^(FRAC_W+1) consecutive periods total int_val*2^(FRAC_W+1) + 2*frac_val + 1 clocks, within ±3. This also holds for `frac_val` = 0.
- R7: No period is shorter than 1 clock. A computed ratio below 1, or an `int_val` of 0, is clamped to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| int_val | input | INT_W | Integer part of the division ratio |
| frac_val | input | FRAC_W | Fractional part, in units of 2^-FRAC_W |
| int_only | input | 1 | 1 = bypass the modulator and divide by `int_val` |
| div_pulse | output | 1 | One-clock marker on the last clock of each output period |
| cur_ratio | output | INT_W+1 | Length in clocks of the period now running |

## Verification
An accumulator holding a wrong value mostly leaves each individual period inside its legal range. It shows up only as a drift in the total length of a window of periods, so that total is compared against the exact value after 2^(FRAC_W+1) periods. A stale delay stage or an uncleared accumulator breaks the repeatability of the sequence after a reset within the first few dozen periods. A wrong reload shows at the very next pulse as a spacing that disagrees with `cur_ratio`. Sampling the inputs outside the pulse cycle shows as a changed length for the period that is already running.

// File: rtl/fbdiv_pkg.sv
// Shared constants and types for the fractional feedback divider.
// Assumes a fixed third-order modulator whose correction fits in 4 signed bits.
package fbdiv_pkg;
    localparam int MASH_ORDER = 3;
    localparam int OFF_W      = 4;
    typedef logic signed [OFF_W-1:0] offset_t;
endpackage

// File: rtl/fbdiv_acc.sv
// One first-order accumulator stage of the cascaded modulator.
// The next sum and its carry are visible combinationally; the stored sum
// advances only when en is high. Assumes addend is already aligned to W bits.
module fbdiv_acc #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_nxt,
    output logic         carry
);
    logic [W-1:0] sum_q;
    logic [W:0]   total;

    // Full-width add to expose the overflow bit as the stage carry.
    always_comb begin
        total   = {1'b0, sum_q} + {1'b0, addend};
        sum_nxt = total[W-1:0];
        carry   = total[W];
    end

    // Store the running sum once per modulator step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (en)
            sum_q <= sum_nxt;
    end
endmodule

// File: rtl/fbdiv_mash3.sv
// Third-order cascaded modulator (three first-order stages in series).
// Each stage integrates the residue of the stage before it. The carries are
// recombined through first and second differences, so the correction stays in
// -3..+4 and its mean equals x / 2^ACC_W. The output is combinational from the
// current state and x; the state advances when adv is high.
module fbdiv_mash3
    import fbdiv_pkg::*;
#(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [ACC_W-1:0] x,
    output offset_t          off
);
    logic [ACC_W-1:0]      feed [MASH_ORDER+1];
    logic [MASH_ORDER-1:0] cy;
    logic                  c2_d, c3_d, c3_dd;

    assign feed[0] = x;

    genvar g;
    generate
        for (g = 0; g < MASH_ORDER; g++) begin : g_stage
            fbdiv_acc #(.W(ACC_W)) acc_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (adv),
                .addend (feed[g]),
                .sum_nxt(feed[g+1]),
                .carry  (cy[g])
            );
        end
    endgenerate

    // Delay the carries of the second and third stages for the difference terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (adv) begin
            c2_d  <= cy[1];
            c3_d  <= cy[2];
            c3_dd <= c3_d;
        end
    end

    // Noise-cancelling recombination: c1 + d(c2) + d2(c3).
    always_comb begin
        off = offset_t'({{(OFF_W-1){1'b0}}, cy[0]})
            + offset_t'({{(OFF_W-1){1'b0}}, cy[1]})
            - offset_t'({{(OFF_W-1){1'b0}}, c2_d})
            + offset_t'({{(OFF_W-1){1'b0}}, cy[2]})
            - offset_t'({{(OFF_W-2){1'b0}}, c3_d, 1'b0})
            + offset_t'({{(OFF_W-1){1'b0}}, c3_dd});
    end
endmodule

// File: rtl/fbdiv_counter.sv
// Reloadable down-counter that sets the length of one output period.
// tc is high on the last clock of a period, and the counter reloads
// load_val-1 on that same edge, so no cycle is lost between periods.
// Assumes load_val is at least 1.
module fbdiv_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_val,
    output logic         tc
);
    logic [W-1:0] cnt_q;

    assign tc = (cnt_q == '0);

    // Count down and reload at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tc)
            cnt_q <= load_val - 1'b1;
        else
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/frac_fb_divider.sv
// Fractional-N feedback divider. At each period boundary it samples the
// integer setting, the fraction and the mode, forms the next ratio from the
// integer setting and the modulator correction (clamped to at least 1), and
// reloads the counter. The modulator sees {frac_val,1} over 2^(FRAC_W+1),
// which adds half a fraction step to the mean. Assumes int_val >= 4 in
// fractional mode if the mean is to be exact.
module frac_fb_divider
    import fbdiv_pkg::*;
#(
    parameter int INT_W  = 7,
    parameter int FRAC_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              int_only,
    output logic              div_pulse,
    output logic [INT_W:0]    cur_ratio
);
    localparam int ACC_W   = FRAC_W + 1;
    localparam int RATIO_W = INT_W + 1;
    localparam int SUM_W   = INT_W + 2;

    logic                      tc;
    logic                      adv;
    offset_t                   off;
    logic signed [SUM_W-1:0]   sum_s;
    logic [RATIO_W-1:0]        next_ratio;
    logic [RATIO_W-1:0]        ratio_q;

    assign adv = tc & ~int_only;

    fbdiv_mash3 #(.ACC_W(ACC_W)) mod_i (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .x    ({frac_val, 1'b1}),
        .off  (off)
    );

    // Form the next ratio: the integer setting alone, or plus the correction, floored at 1.
    always_comb begin
        sum_s = $signed({2'b00, int_val})
              + $signed({{(SUM_W-OFF_W){off[OFF_W-1]}}, off});
        if (int_only) begin
            next_ratio = {1'b0, int_val};
            if (int_val == '0)
                next_ratio = RATIO_W'(1);
        end else begin
            next_ratio = sum_s[RATIO_W-1:0];
            if (sum_s < $signed(SUM_W'(1)))
                next_ratio = RATIO_W'(1);
        end
    end

    fbdiv_counter #(.W(RATIO_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_val(next_ratio),
        .tc      (tc)
    );

    // Record the ratio of the period that starts at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= RATIO_W'(1);
        else if (tc)
            ratio_q <= next_ratio;
    end

    assign div_pulse = tc;
    assign cur_ratio = ratio_q;
endmodule

// File: rtl/frac_fb_divider_chk.sv
// Property checker for frac_fb_divider, bound to every instance below.
// It watches only the ports and keeps its own count of the spacing between pulses.
module frac_fb_divider_chk #(
    parameter int INT_W   = 7,
    parameter int RATIO_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INT_W-1:0]   int_val,
    input logic               int_only,
    input logic               div_pulse,
    input logic [RATIO_W-1:0] cur_ratio
);
    localparam int EW = RATIO_W + 1;

    logic [RATIO_W-1:0] since_q;
    logic               low_seen = 1'b0;

    // Count the clocks since the last pulse, independently of the design's counter.
    always @(posedge clk) begin
        if (!rst_n || div_pulse)
            since_q <= '0;
        else
            since_q <= since_q + 1'b1;
        low_seen <= !rst_n;
    end

    // R1: state seen while the reset is held.
    always @(negedge clk) begin
        if (low_seen && !rst_n)
            assert_reset_state_R1: assert (cur_ratio == RATIO_W'(1) && div_pulse)
                else $error("reset state wrong");
    end

    // R2: pulse spacing equals the announced ratio.
    assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (since_q + 1'b1 == cur_ratio));

    // R3: the ratio changes only at a boundary.
    assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(cur_ratio));

    // R4: integer-only mode divides by the integer setting exactly.
    assert_int_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && int_only && int_val != '0) |=> (cur_ratio == RATIO_W'($past(int_val))));

    // R5: the fractional-mode ratio stays within the correction range.
    assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !int_only && int_val >= INT_W'(4)) |=>
            ((EW'(cur_ratio) + EW'(3) >= EW'($past(int_val))) &&
             (EW'(cur_ratio) <= EW'($past(int_val)) + EW'(4))));

    // R7: no zero-length period.
    assert_ratio_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ratio != '0);
endmodule

bind frac_fb_divider frac_fb_divider_chk #(.INT_W(INT_W), .RATIO_W(INT_W + 1)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_val  (int_val),
    .int_only (int_only),
    .div_pulse(div_pulse),
    .cur_ratio(cur_ratio)
);

// File: tb/frac_fb_divider_tb_top.sv
// Scoreboard bench: driver tasks queue the expected period items, and a
// monitor measures each period at the falling edge and pops the items.
module frac_fb_divider_tb_top;
    localparam int INT_W  = 7;
    localparam int FRAC_W = 10;
    localparam int WIN    = 1 << (FRAC_W + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [INT_W-1:0]  int_val;
    logic [FRAC_W-1:0] frac_val;
    logic              int_only;
    logic              div_pulse;
    logic [INT_W:0]    cur_ratio;

    always #10 clk = ~clk;

    frac_fb_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
        .int_only(int_only), .div_pulse(div_pulse), .cur_ratio(cur_ratio)
    );

    // kind 0: one exact period; 1: window sum plus per-period range; 2: range only
    typedef struct {
        int    kind;
        int    lo;
        int    hi;
        int    count;
        int    rlo;
        int    rhi;
        string tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    int gap = 0, acc = 0, seen = 0, bad = 0;
    int rec1 [16];
    int rec2 [16];

    // Monitor: measure each period and compare it with the head of the queue.
    always @(negedge clk) begin
        int p;
        if (!rst_n) begin
            gap = 0; acc = 0; seen = 0; bad = 0;
        end else begin
            gap++;
            if (div_pulse) begin
                p = gap;
                gap = 0;
                if (sb.size() > 0) begin
                    if (sb[0].kind == 0) begin
                        checks++;
                        if (p != sb[0].lo) begin
                            errors++;
                            $display("FAIL %s period actual %0d expected %0d", sb[0].tag, p, sb[0].lo);
                        end
                        void'(sb.pop_front());
                    end else begin
                        seen++;
                        acc += p;
                        if (p < sb[0].rlo || p > sb[0].rhi) bad++;
                        if (seen == sb[0].count) begin
                            checks++;
                            if (bad != 0) begin
                                errors++;
                                $display("FAIL R5/R7 %s period out of range %0d times actual-range %0d..%0d expected 0 violations",
                                         sb[0].tag, bad, sb[0].rlo, sb[0].rhi);
                            end
                            if (sb[0].kind == 1) begin
                                checks++;
                                if (acc < sb[0].lo || acc > sb[0].hi) begin
                                    errors++;
                                    $display("FAIL %s window total actual %0d expected %0d..%0d",
                                             sb[0].tag, acc, sb[0].lo, sb[0].hi);
                                end
                            end
                            seen = 0; acc = 0; bad = 0;
                            void'(sb.pop_front());
                        end
                    end
                end
            end
        end
    end

    // Wait for an idle scoreboard, then change the inputs in a pulse cycle.
    task automatic apply(input int m, input int f, input bit io);
        wait (sb.size() == 0);
        do @(negedge clk); while (!div_pulse);
        #1;
        int_val  = INT_W'(m);
        frac_val = FRAC_W'(f);
        int_only = io;
    endtask

    task automatic push_exact(input int v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.kind = 0; it.lo = v; it.hi = v; it.count = 1; it.rlo = v; it.rhi = v; it.tag = tag;
            sb.push_back(it);
        end
    endtask

    task automatic push_window(input int m, input int f, input string tag);
        item_t it;
        int exp_total;
        exp_total = m * WIN + 2 * f + 1;
        it.kind = 1; it.lo = exp_total - 3; it.hi = exp_total + 3; it.count = WIN;
        it.rlo = (m - 3 < 1) ? 1 : m - 3; it.rhi = m + 4; it.tag = tag;
        sb.push_back(it);
    endtask

    // Reset with given inputs and record the first 16 period lengths.
    task automatic reset_record(output int rec [16]);
        int c;
        int k;
        wait (sb.size() == 0);
        @(negedge clk); #1;
        rst_n = 1'b0; int_val = 7; frac_val = 300; int_only = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        c = 0; k = 0;
        while (k < 16) begin
            @(negedge clk);
            c++;
            if (div_pulse) begin
                rec[k] = c;
                c = 0;
                k++;
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
        $finish;
    end

    // Stimulus sequence.
    initial begin
        rst_n = 1'b0; int_val = 5; frac_val = 0; int_only = 1'b0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (!(div_pulse == 1'b1 && cur_ratio == 1)) begin
                errors++;
                $display("FAIL R1 reset state actual pulse=%0b ratio=%0d expected pulse=1 ratio=1",
                         div_pulse, cur_ratio);
            end
        end
        #1 rst_n = 1'b1;

        // R4: integer mode ignores the fraction
        apply(13, 341, 1'b1);
        push_exact(13, 6, "R4");

        // R2: ratio 1 gives back-to-back pulses
        apply(1, 0, 1'b1);
        push_exact(1, 8, "R2");

        // R3: a change in the middle of a period takes effect only at the next boundary
        apply(10, 0, 1'b1);
        push_exact(10, 1, "R3");
        repeat (3) @(negedge clk);
        #1 int_val = 20;
        push_exact(20, 3, "R3");

        // R6 / R5: window totals, including a zero fraction
        apply(5, 0, 1'b0);
        push_window(5, 0, "R6 zero-fraction");
        apply(6, 1023, 1'b0);
        push_window(6, 1023, "R6 full-fraction");
        apply(9, 341, 1'b0);
        push_window(9, 341, "R6 mid-fraction");
        apply(12, 700, 1'b0);
        push_window(12, 700, "R6 R5 high-ratio");

        // R7: small integer setting, clamped floor
        apply(2, 900, 1'b0);
        begin
            item_t it;
            it.kind = 2; it.lo = 0; it.hi = 0; it.count = 300; it.rlo = 1; it.rhi = 6; it.tag = "R7";
            sb.push_back(it);
        end

        // R1: restart determinism after reset
        reset_record(rec1);
        reset_record(rec2);
        for (int i = 0; i < 16; i++) begin
            checks++;
            if (rec1[i] != rec2[i] || rec1[i] < 4 || rec1[i] > 11) begin
                errors++;
                $display("FAIL R1 restart period %0d actual %0d expected %0d (range 4..11)",
                         i, rec2[i], rec1[i]);
            end
        end

        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule